// File: doc/BRIEF.md
# Interrupt Split-Transaction Progress Tracker

This block holds the progress state of one queue head that carries a periodic interrupt transfer through a hub's transaction translator. A start-split event opens a transfer. It clears the progress mask and stores the current frame number as the tag for the next complete-split. For an OUT transfer it also records the bytes sent. Each complete-split event then reports the micro-frame it ran in. The tracker checks that every expected complete-split slot before that one has already run, and records the new slot.

A skipped slot or an unrecoverable link error counts as a lost-data event. On an IN transfer this halts the queue head. The halt stays set until a clear input removes it, and all split events are ignored while it is set. On an OUT transfer a lost-data event only gives an error pulse and drops the progress made so far, and the queue head stays live. A combinational hint tells the scheduler when a complete-split is due. That is when the frame tag matches the current frame and the micro-frame is one of the expected slots.

Top module: `split_prog_tracker`

## Requirements
- R1: After reset the mask, frame tag, byte count, halt, error and due outputs are all zero, and the tracker is inactive.
- R2: A start-split takes effect on the next clock edge. It clears the mask, loads the frame tag with `frame_i` and makes the tracker active. It loads the byte count with `bytes_i` when `dir_in_i`=0 (OUT) and with 0 when `dir_in_i`=1 (IN).
- R3: A complete-split that is not lost sets mask bit `uframe_i` on the next edge.
- R4: A complete-split is lost if `link_err_i` is 1, or if any bit k < `uframe_i` is set in `cs_slots_i` while mask bit k is clear.
- R5: A lost complete-split on an IN transfer sets `halt_o` on the next edge and pulses `err_o` high for exactly one cycle. The mask is kept.
- R6: A lost complete-split on an OUT transfer pulses `err_o` and leaves `halt_o` low. It clears the mask and makes the tracker inactive.
- R7: On an IN transfer each good complete-split adds `bytes_i` to the byte count, modulo 2^10. On an OUT transfer complete-splits leave the byte count unchanged.
- R8: `cs_due_o` is high, in the same cycle, exactly when the tracker is active, not halted, `frame_i` equals the frame tag and bit `uframe_i` of `cs_slots_i` is set.
- R9: A good complete-split in micro-frame 7 increments the frame tag, modulo 32.
- R10: `halt_o` stays set until `halt_clr_i` is high at a clock edge. While it is set, start-split and complete-split events change no output.
- R11: A complete-split that arrives while the tracker is inactive is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ss_valid_i | input | 1 | Start-split executed this cycle |
| cs_valid_i | input | 1 | Complete-split executed this cycle |
| dir_in_i | input | 1 | Transfer direction at start-split: 1 IN, 0 OUT |
| uframe_i | input | 3 | Current micro-frame index |
| frame_i | input | 5 | Current frame number (low bits) |
| bytes_i | input | 10 | Payload bytes of this event |
| link_err_i | input | 1 | Unrecoverable link error on this complete-split |
| cs_slots_i | input | 8 | Micro-frames in which complete-splits are expected |
| halt_clr_i | input | 1 | Clear the halt |
| prog_mask_o | output | 8 | Executed complete-split micro-frames |
| frame_tag_o | output | 5 | Frame in which the next complete-split is due |
| byte_cnt_o | output | 10 | Sent or accumulated payload bytes |
| halt_o | output | 1 | Queue head halted |
| err_o | output | 1 | One-cycle lost-data pulse |
| cs_due_o | output | 1 | Complete-split may be issued now |

## Verification
`cs_due_o` is combinational, so the bench compares it one time step after driving inputs and before the edge. Every registered result (mask, tag, byte count, halt, error pulse) is due one edge after the event that causes it, and the bench compares those at the following falling edge. A behavioural model advances at the same edges and is compared on every cycle. The sequences cover an in-order IN transfer, a skipped slot on IN and on OUT, a link error, events during a halt, and the frame-tag wrap.

// File: rtl/split_prog_pkg.sv
package split_prog_pkg;
  typedef enum logic {DIR_OUT = 1'b0, DIR_IN = 1'b1} xfer_dir_e;
endpackage

// File: rtl/split_order_chk.sv
module split_order_chk #(
  parameter int UF_N = 8,
  localparam int UF_W = $clog2(UF_N)
) (
  input  logic [UF_N-1:0] exp_i,
  input  logic [UF_N-1:0] done_i,
  input  logic [UF_W-1:0] uf_i,
  output logic            skip_o
);
  logic [UF_N-1:0] below;

  for (genvar k = 0; k < UF_N; k++) begin : g_below
    assign below[k] = (UF_W'(k) < uf_i);
  end

  assign skip_o = |(exp_i & below & ~done_i);

  // first slot has no predecessor
  always_comb begin
    if (uf_i == '0) p_first_slot_clean_r4 : assert (!skip_o);
  end
endmodule

// File: rtl/split_byte_acc.sv
module split_byte_acc #(
  parameter int BYTE_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] load_val_i,
  input  logic              add_i,
  input  logic [BYTE_W-1:0] add_val_i,
  output logic [BYTE_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (load_i) cnt_o <= load_val_i;
    else if (add_i)  cnt_o <= cnt_o + add_val_i;
  end

  p_idle_hold_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && !add_i |=> $stable(cnt_o));
endmodule

// File: rtl/split_prog_tracker.sv
module split_prog_tracker
  import split_prog_pkg::*;
#(
  parameter int UF_N    = 8,
  parameter int FRAME_W = 5,
  parameter int BYTE_W  = 10,
  localparam int UF_W   = $clog2(UF_N)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ss_valid_i,
  input  logic               cs_valid_i,
  input  logic               dir_in_i,
  input  logic [UF_W-1:0]    uframe_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [BYTE_W-1:0]  bytes_i,
  input  logic               link_err_i,
  input  logic [UF_N-1:0]    cs_slots_i,
  input  logic               halt_clr_i,
  output logic [UF_N-1:0]    prog_mask_o,
  output logic [FRAME_W-1:0] frame_tag_o,
  output logic [BYTE_W-1:0]  byte_cnt_o,
  output logic               halt_o,
  output logic               err_o,
  output logic               cs_due_o
);
  localparam logic [UF_W-1:0] UF_LAST = UF_W'(UF_N - 1);

  logic               active_q, halt_q, err_q;
  xfer_dir_e          dir_q;
  logic [UF_N-1:0]    mask_q;
  logic [FRAME_W-1:0] tag_q;
  logic               skip, ss_go, cs_go, lost, cs_ok;

  split_order_chk #(.UF_N(UF_N)) u_order (
    .exp_i (cs_slots_i),
    .done_i(mask_q),
    .uf_i  (uframe_i),
    .skip_o(skip)
  );

  assign ss_go = ss_valid_i & ~halt_q;
  assign cs_go = cs_valid_i & ~ss_valid_i & ~halt_q & active_q;
  assign lost  = cs_go & (skip | link_err_i);
  assign cs_ok = cs_go & ~lost;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      dir_q    <= DIR_OUT;
      mask_q   <= '0;
      tag_q    <= '0;
    end else if (ss_go) begin
      active_q <= 1'b1;
      dir_q    <= xfer_dir_e'(dir_in_i);
      mask_q   <= '0;
      tag_q    <= frame_i;
    end else if (lost) begin
      if (dir_q == DIR_OUT) begin
        active_q <= 1'b0;
        mask_q   <= '0;
      end
    end else if (cs_ok) begin
      mask_q[uframe_i] <= 1'b1;
      if (uframe_i == UF_LAST) tag_q <= tag_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      err_q <= lost;
      if (halt_clr_i)                     halt_q <= 1'b0;
      else if (lost && dir_q == DIR_IN)   halt_q <= 1'b1;
    end
  end

  split_byte_acc #(.BYTE_W(BYTE_W)) u_bytes (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (ss_go),
    .load_val_i(dir_in_i ? '0 : bytes_i),
    .add_i     (cs_ok && dir_q == DIR_IN),
    .add_val_i (bytes_i),
    .cnt_o     (byte_cnt_o)
  );

  assign cs_due_o    = active_q & ~halt_q & (frame_i == tag_q) & cs_slots_i[uframe_i];
  assign prog_mask_o = mask_q;
  assign frame_tag_o = tag_q;
  assign halt_o      = halt_q;
  assign err_o       = err_q;

  p_ss_clear_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_go |=> mask_q == '0 && tag_q == $past(frame_i) && active_q);
  p_mask_set_r3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ok |=> mask_q[$past(uframe_i)]);
  p_in_halt_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost && dir_q == DIR_IN && !halt_clr_i |=> halt_q && err_q);
  p_out_no_halt_r6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost && dir_q == DIR_OUT |=> err_q && !halt_q && !active_q && mask_q == '0);
  p_halt_sticky_r10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_q && !halt_clr_i |=> halt_q);
  p_halt_freeze_r10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_q |=> $stable(mask_q) && $stable(tag_q) && $stable(byte_cnt_o) && !err_q);
endmodule

// File: tb/split_prog_tracker_tb.sv
module split_prog_tracker_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ss_v = 0, cs_v = 0, din = 0, lerr = 0, hclr = 0;
  logic [2:0] uf = 0;
  logic [4:0] fr = 0;
  logic [9:0] nb = 0;
  logic [7:0] slots = 0;
  logic [7:0] mask_o;
  logic [4:0] tag_o;
  logic [9:0] bytes_o;
  logic       halt_o, err_o, due_o;

  int errors = 0, checks = 0;
  bit finished = 0;
  // reference model state
  int m_mask = 0, m_tag = 0, m_bytes = 0;
  bit m_halt = 0, m_err = 0, m_act = 0, m_dir = 0;

  always #10 clk = ~clk;

  split_prog_tracker dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ss_valid_i(ss_v), .cs_valid_i(cs_v),
    .dir_in_i(din), .uframe_i(uf), .frame_i(fr), .bytes_i(nb),
    .link_err_i(lerr), .cs_slots_i(slots), .halt_clr_i(hclr),
    .prog_mask_o(mask_o), .frame_tag_o(tag_o), .byte_cnt_o(bytes_o),
    .halt_o(halt_o), .err_o(err_o), .cs_due_o(due_o));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cmp_regs();
    chk("R3 mask", int'(mask_o), m_mask);
    chk("R9 tag", int'(tag_o), m_tag);
    chk("R7 bytes", int'(bytes_o), m_bytes);
    chk("R10 halt", int'(halt_o), int'(m_halt));
    chk("R5 err", int'(err_o), int'(m_err));
  endtask

  function automatic bit model_due();
    return m_act && !m_halt && int'(fr) == m_tag && slots[uf];
  endfunction

  task automatic model_edge();
    bit lost = 0, skip = 0;
    if (ss_v && !m_halt) begin
      m_act = 1; m_dir = din; m_mask = 0; m_tag = fr; m_bytes = din ? 0 : int'(nb);
    end else if (cs_v && m_act && !m_halt) begin
      for (int k = 0; k < int'(uf); k++) if (slots[k] && !m_mask[k]) skip = 1;
      if (skip || lerr) begin
        lost = 1;
        if (!m_dir) begin m_act = 0; m_mask = 0; end
      end else begin
        m_mask = m_mask | (1 << uf);
        if (m_dir) m_bytes = (m_bytes + int'(nb)) % 1024;
        if (uf == 7) m_tag = (m_tag + 1) % 32;
      end
    end
    m_err = lost;
    if (hclr) m_halt = 0;
    else if (lost && m_dir) m_halt = 1;
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(bit s, bit c, bit d, bit le, bit hc, int u, int f, int n);
    ss_v = s; cs_v = c; din = d; lerr = le; hclr = hc;
    uf = 3'(u); fr = 5'(f); nb = 10'(n);
    #1 chk("R8 due", int'(due_o), int'(model_due()));
    @(posedge clk);
    model_edge();
    @(negedge clk);
    ss_v = 0; cs_v = 0; lerr = 0; hclr = 0;
    cmp_regs();
  endtask

  task automatic ss(bit d, int f, int n);          step(1, 0, d, 0, 0, 0, f, n); endtask
  task automatic cs(int u, int f, int n, bit le);  step(0, 1, 0, le, 0, u, f, n); endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 mask", int'(mask_o), 0); chk("R1 tag", int'(tag_o), 0);
    chk("R1 bytes", int'(bytes_o), 0); chk("R1 halt", int'(halt_o), 0);
    chk("R1 err", int'(err_o), 0); chk("R1 due", int'(due_o), 0);
    rst_n = 1;
    @(negedge clk);
    slots = 8'b0011_1100;
    // R11: complete-split while inactive
    cs(2, 0, 7, 0);
    chk("R11 mask untouched", int'(mask_o), 0);
    // in-order IN transfer
    ss(1, 3, 99);
    chk("R2 IN bytes zero", int'(bytes_o), 0);
    chk("R2 tag load", int'(tag_o), 3);
    step(0, 0, 0, 0, 0, 2, 4, 0);              // due low on wrong frame (R8)
    cs(2, 3, 10, 0); cs(3, 3, 20, 0); cs(4, 3, 30, 0); cs(5, 3, 5, 0);
    chk("R7 IN accumulate", int'(bytes_o), 65);
    chk("R3 in-order mask", int'(mask_o), 8'h3C);
    // OUT transfer with skipped slot 3
    ss(0, 7, 40);
    chk("R2 OUT bytes", int'(bytes_o), 40);
    cs(2, 7, 9, 0);
    chk("R7 OUT bytes held", int'(bytes_o), 40);
    cs(4, 7, 9, 0);
    chk("R6 err pulse", int'(err_o), 1);
    chk("R6 no halt", int'(halt_o), 0);
    chk("R6 mask cleared", int'(mask_o), 0);
    cs(5, 7, 9, 0);
    chk("R6 inactive after loss", int'(mask_o), 0);
    chk("R5 err one cycle", int'(err_o), 0);
    // IN transfer with skipped slot 3
    ss(1, 9, 0);
    cs(2, 9, 12, 0);
    cs(4, 9, 12, 0);
    chk("R4 skip detected", int'(err_o), 1);
    chk("R5 halt set", int'(halt_o), 1);
    chk("R5 mask kept", int'(mask_o), 8'h04);
    ss(0, 20, 50); cs(3, 9, 1, 0);
    chk("R10 ignored tag", int'(tag_o), 9);
    chk("R10 ignored bytes", int'(bytes_o), 12);
    step(0, 0, 0, 0, 1, 0, 0, 0);
    chk("R10 cleared", int'(halt_o), 0);
    // link error on first slot
    ss(1, 12, 0);
    cs(2, 12, 8, 1);
    chk("R4 link error halts", int'(halt_o), 1);
    step(0, 0, 0, 0, 1, 0, 0, 0);
    // frame tag advance and wrap
    slots = 8'b1100_0000;
    ss(1, 31, 0);
    cs(6, 31, 3, 0); cs(7, 31, 4, 0);
    chk("R9 tag wrap", int'(tag_o), 0);
    slots = 8'b0000_0001;
    step(0, 0, 0, 0, 0, 0, 0, 0);             // due high in new frame (R8)
    cs(0, 0, 2, 0);
    chk("R7 bytes after wrap", int'(bytes_o), 9);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule